// File: doc/BRIEF.md
# Receiver Lock Timeout Monitor

This block checks whether a video receiver regains lock after its transmit source changes. A one-cycle source-change pulse starts two independent watch windows. One window applies to the receiver's timing-reference lock flag and the other to its frame lock flag. Each window is a parameter counted in clock cycles. The defaults equal 500 ms and 1 s at a 50 MHz clock. Both lengths must be set long enough to cover the latency of the transmitter, the loopback cable and the receiver.

If a lock flag is sampled high at any point inside its window, that check passes and resolves at once. If the window runs out without the flag being seen high, the check fails and a saturating error counter for that lock type advances by one. Each resolved check produces a one-cycle done strobe with a pass bit, so a test harness can log every individual result. The counters keep their totals over a whole reliability run and clear only on reset.

Top module: `rx_lock_watch`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, both error counters read 0 and all done and pass outputs are 0.
- R2: After a pulse sampled at edge P, a lock flag sampled high at edge P+k, for 1 <= k <= its window length W, makes that type's done and pass outputs read 1 for exactly the one cycle after edge P+k. The error counter does not change.
- R3: If a lock flag is low at every edge from P+1 to P+W, done reads 1 with pass 0 for the one cycle after edge P+W. At that same edge the matching error counter increases by one.
- R4: The timing-reference check uses window `TREF_WIN_CYC` and counter `tref_err_cnt`. The frame check uses `FRAME_WIN_CYC` and `frame_err_cnt`. The result of one check never changes the other check's outputs.
- R5: Each pulse gives at most one result per lock type. While no window is open, lock flag activity produces no strobe and does not change either counter.
- R6: A pulse that arrives while a window is open restarts both windows from that pulse. It records no error and emits no strobe for the window it cut short.
- R7: If a pulse is sampled on the same edge at which a window would expire, the pulse wins: no failure and no strobe are recorded for the old window.
- R8: Each error counter is `ERR_W` bits wide (16 by default). It stays at its all-ones value once reached and clears only on reset.
- R9: A lock flag is not sampled on the edge that samples the pulse. A flag that is high only on that edge does not count as lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_chg | input | 1 | One-cycle pulse: a new source is being transmitted |
| tref_lock | input | 1 | Receiver timing-reference lock flag |
| frame_lock | input | 1 | Receiver frame lock flag |
| tref_err_cnt | output | ERR_W | Saturating count of timing-reference lock failures |
| frame_err_cnt | output | ERR_W | Saturating count of frame lock failures |
| tref_done | output | 1 | One-cycle strobe: timing-reference check resolved |
| tref_pass | output | 1 | Result of the timing-reference check, valid with tref_done |
| frame_done | output | 1 | One-cycle strobe: frame check resolved |
| frame_pass | output | 1 | Result of the frame check, valid with frame_done |

## Verification
Two functions can meet on one edge: the expiry of an open window and the re-arm caused by a new source-change pulse. The bench provokes this by placing the second pulse exactly W edges after the first. At that edge the expiry would otherwise record a failure. The bench judges the outcome by checking that no strobe appears and neither counter moves for the old window, and that the re-armed windows then resolve at the cycles computed from the second pulse.

// File: rtl/rx_lock_watch_pkg.sv
package rx_lock_watch_pkg;

    localparam int N_LOCK    = 2;
    localparam int IDX_TREF  = 0;
    localparam int IDX_FRAME = 1;

    // Result of one lock check on the edge it resolves.
    typedef struct packed {
        logic done;
        logic pass;
    } verdict_t;

    // Watch-window state.
    typedef enum logic {
        WIN_IDLE  = 1'b0,
        WIN_WATCH = 1'b1
    } win_state_e;

    function automatic int unsigned ms_to_cyc(input int unsigned clk_hz,
                                              input int unsigned ms);
        return (clk_hz / 1000) * ms;
    endfunction

endpackage

// File: rtl/lock_window.sv
module lock_window
    import rx_lock_watch_pkg::*;
#(
    parameter int unsigned WIN = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     arm,
    input  logic     lock,
    output verdict_t res
);
    localparam int unsigned CW = (WIN < 2) ? 1 : $clog2(WIN + 1);
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);

    win_state_e    state;
    logic [CW-1:0] elapsed;

    // A new pulse takes priority over any resolution of the open window.
    always_comb begin
        res.done = (state == WIN_WATCH) && !arm && (lock || (elapsed == LAST));
        res.pass = (state == WIN_WATCH) && !arm && lock;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= WIN_IDLE;
            elapsed <= '0;
        end else if (arm) begin
            state   <= WIN_WATCH;
            elapsed <= '0;
        end else if (res.done) begin
            state   <= WIN_IDLE;
            elapsed <= '0;
        end else if (state == WIN_WATCH) begin
            elapsed <= elapsed + CW'(1);
        end
    end

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bump,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (bump && (cnt != {W{1'b1}})) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/rx_lock_watch.sv
module rx_lock_watch
    import rx_lock_watch_pkg::*;
#(
    parameter int unsigned TREF_WIN_CYC  = ms_to_cyc(50_000_000, 500),
    parameter int unsigned FRAME_WIN_CYC = ms_to_cyc(50_000_000, 1000),
    parameter int          ERR_W         = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_chg,
    input  logic             tref_lock,
    input  logic             frame_lock,
    output logic [ERR_W-1:0] tref_err_cnt,
    output logic [ERR_W-1:0] frame_err_cnt,
    output logic             tref_done,
    output logic             tref_pass,
    output logic             frame_done,
    output logic             frame_pass
);
    logic [N_LOCK-1:0] lock_vec;
    verdict_t          now_v [N_LOCK];
    verdict_t          reg_v [N_LOCK];
    logic [ERR_W-1:0]  errs  [N_LOCK];

    assign lock_vec[IDX_TREF]  = tref_lock;
    assign lock_vec[IDX_FRAME] = frame_lock;

    for (genvar g = 0; g < N_LOCK; g++) begin : g_lock
        localparam int unsigned WIN_G = (g == IDX_TREF) ? TREF_WIN_CYC : FRAME_WIN_CYC;

        lock_window #(.WIN(WIN_G)) u_win (
            .clk  (clk),
            .rst  (rst),
            .arm  (src_chg),
            .lock (lock_vec[g]),
            .res  (now_v[g])
        );

        sat_counter #(.W(ERR_W)) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .bump (now_v[g].done && !now_v[g].pass),
            .cnt  (errs[g])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                reg_v[g] <= '0;
            end else begin
                reg_v[g] <= now_v[g];
            end
        end
    end

    assign tref_err_cnt  = errs[IDX_TREF];
    assign frame_err_cnt = errs[IDX_FRAME];
    assign tref_done     = reg_v[IDX_TREF].done;
    assign tref_pass     = reg_v[IDX_TREF].pass;
    assign frame_done    = reg_v[IDX_FRAME].done;
    assign frame_pass    = reg_v[IDX_FRAME].pass;

endmodule

// File: rtl/rx_lock_watch_chk.sv
module rx_lock_watch_chk #(
    parameter int ERR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             src_chg,
    input logic             tref_lock,
    input logic             frame_lock,
    input logic [ERR_W-1:0] tref_err_cnt,
    input logic [ERR_W-1:0] frame_err_cnt,
    input logic             tref_done,
    input logic             tref_pass,
    input logic             frame_done,
    input logic             frame_pass
);
    localparam logic [ERR_W-1:0] MAXC = {ERR_W{1'b1}};

    // R2: a pass needs the flag seen high on the resolving edge
    a_r2_tref_pass_seen: assert property (@(posedge clk) disable iff (rst)
        (tref_done && tref_pass) |-> $past(tref_lock));
    a_r2_frame_pass_seen: assert property (@(posedge clk) disable iff (rst)
        (frame_done && frame_pass) |-> $past(frame_lock));

    // R3: a failure advances its counter by one unless saturated
    a_r3_tref_fail_bumps: assert property (@(posedge clk) disable iff (rst)
        (tref_done && !tref_pass && $past(tref_err_cnt) != MAXC)
            |-> tref_err_cnt == $past(tref_err_cnt) + ERR_W'(1));
    a_r3_frame_fail_bumps: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !frame_pass && $past(frame_err_cnt) != MAXC)
            |-> frame_err_cnt == $past(frame_err_cnt) + ERR_W'(1));

    // R5: counters move only with a failure strobe
    a_r5_tref_cnt_steady: assert property (@(posedge clk) disable iff (rst)
        !(tref_done && !tref_pass) |-> $stable(tref_err_cnt));
    a_r5_frame_cnt_steady: assert property (@(posedge clk) disable iff (rst)
        !(frame_done && !frame_pass) |-> $stable(frame_err_cnt));

    // R5: strobes last one cycle
    a_r5_tref_single: assert property (@(posedge clk) disable iff (rst)
        tref_done |=> !tref_done);
    a_r5_frame_single: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R6 / R7: the edge sampling a pulse resolves nothing
    a_r7_pulse_wins: assert property (@(posedge clk) disable iff (rst)
        $past(src_chg) |-> (!tref_done && !frame_done));

    // R8: saturated counters hold
    a_r8_tref_no_wrap: assert property (@(posedge clk) disable iff (rst)
        ($past(tref_err_cnt) == MAXC) |-> (tref_err_cnt == MAXC));
    a_r8_frame_no_wrap: assert property (@(posedge clk) disable iff (rst)
        ($past(frame_err_cnt) == MAXC) |-> (frame_err_cnt == MAXC));

endmodule

bind rx_lock_watch rx_lock_watch_chk #(.ERR_W(ERR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .src_chg       (src_chg),
    .tref_lock     (tref_lock),
    .frame_lock    (frame_lock),
    .tref_err_cnt  (tref_err_cnt),
    .frame_err_cnt (frame_err_cnt),
    .tref_done     (tref_done),
    .tref_pass     (tref_pass),
    .frame_done    (frame_done),
    .frame_pass    (frame_pass)
);

// File: tb/rx_lock_watch_tb.sv
module rx_lock_watch_tb;

    localparam int TW    = 8;
    localparam int FW    = 14;
    localparam int EW    = 3;
    localparam int MAXC  = (1 << EW) - 1;

    typedef struct {
        int    edge_no;
        bit    pass;
        int    cnt;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          src_chg = 1'b0;
    logic          tref_lock = 1'b0;
    logic          frame_lock = 1'b0;
    logic [EW-1:0] tref_err_cnt, frame_err_cnt;
    logic          tref_done, tref_pass, frame_done, frame_pass;

    int  cyc = 0;
    int  checks = 0;
    int  errors = 0;
    int  model [2] = '{0, 0};
    bit  finished = 1'b0;
    exp_t q_tref [$];
    exp_t q_frame [$];

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    rx_lock_watch #(
        .TREF_WIN_CYC (TW),
        .FRAME_WIN_CYC(FW),
        .ERR_W        (EW)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .src_chg      (src_chg),
        .tref_lock    (tref_lock),
        .frame_lock   (frame_lock),
        .tref_err_cnt (tref_err_cnt),
        .frame_err_cnt(frame_err_cnt),
        .tref_done    (tref_done),
        .tref_pass    (tref_pass),
        .frame_done   (frame_done),
        .frame_pass   (frame_pass)
    );

    task automatic note(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    // Driver side: push one expected result, updating the counter model.
    task automatic push(input int idx, input int edge_no, input bit pass, input string tag);
        exp_t e;
        if (!pass && model[idx] < MAXC) model[idx]++;
        e.edge_no = edge_no;
        e.pass    = pass;
        e.cnt     = model[idx];
        e.tag     = tag;
        if (idx == 0) q_tref.push_back(e);
        else          q_frame.push_back(e);
    endtask

    // lt / lf: offset of the first edge with the flag high (0 = never,
    // -1 = high only on the pulse edge).
    task automatic do_window(input int lt, input int lf, input string tag);
        int p;
        p = cyc + 1;
        if (lt >= 1 && lt <= TW) push(0, p + lt, 1'b1, tag);
        else                     push(0, p + TW, 1'b0, tag);
        if (lf >= 1 && lf <= FW) push(1, p + lf, 1'b1, tag);
        else                     push(1, p + FW, 1'b0, tag);
        src_chg    = 1'b1;
        tref_lock  = (lt == -1);
        frame_lock = (lf == -1);
        @(negedge clk);
        src_chg = 1'b0;
        for (int k = 1; k <= FW + 2; k++) begin
            tref_lock  = (lt >= 1) && (k >= lt);
            frame_lock = (lf >= 1) && (k >= lf);
            @(negedge clk);
        end
        tref_lock  = 1'b0;
        frame_lock = 1'b0;
    endtask

    task automatic pulse_only(input int wait_negs);
        src_chg = 1'b1;
        @(negedge clk);
        src_chg = 1'b0;
        for (int k = 0; k < wait_negs; k++) @(negedge clk);
    endtask

    task automatic idle_toggle();
        for (int k = 0; k < 6; k++) begin
            tref_lock  = k[0];
            frame_lock = ~k[0];
            @(negedge clk);
            note(!tref_done && !frame_done && int'(tref_err_cnt) == model[0]
                 && int'(frame_err_cnt) == model[1],
                 $sformatf("R5 idle: done=%0b/%0b cnt=%0d/%0d expected 0/0 %0d/%0d",
                           tref_done, frame_done, tref_err_cnt, frame_err_cnt,
                           model[0], model[1]));
        end
        tref_lock  = 1'b0;
        frame_lock = 1'b0;
    endtask

    // Monitor side: pop and compare as strobes appear.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (tref_done) begin
                if (q_tref.size() == 0) begin
                    note(1'b0, $sformatf("R5 tref unexpected strobe at %0d pass=%0b expected none",
                                         cyc, tref_pass));
                end else begin
                    exp_t e;
                    e = q_tref.pop_front();
                    note(e.edge_no == cyc && e.pass == tref_pass && e.cnt == int'(tref_err_cnt),
                         $sformatf("%s tref: edge=%0d pass=%0b cnt=%0d expected edge=%0d pass=%0b cnt=%0d",
                                   e.tag, cyc, tref_pass, tref_err_cnt, e.edge_no, e.pass, e.cnt));
                end
            end else if (q_tref.size() != 0 && q_tref[0].edge_no < cyc) begin
                exp_t e;
                e = q_tref.pop_front();
                note(1'b0, $sformatf("%s tref missing strobe: actual none expected edge=%0d",
                                     e.tag, e.edge_no));
            end
            if (frame_done) begin
                if (q_frame.size() == 0) begin
                    note(1'b0, $sformatf("R5 frame unexpected strobe at %0d pass=%0b expected none",
                                         cyc, frame_pass));
                end else begin
                    exp_t e;
                    e = q_frame.pop_front();
                    note(e.edge_no == cyc && e.pass == frame_pass && e.cnt == int'(frame_err_cnt),
                         $sformatf("%s frame: edge=%0d pass=%0b cnt=%0d expected edge=%0d pass=%0b cnt=%0d",
                                   e.tag, cyc, frame_pass, frame_err_cnt, e.edge_no, e.pass, e.cnt));
                end
            end else if (q_frame.size() != 0 && q_frame[0].edge_no < cyc) begin
                exp_t e;
                e = q_frame.pop_front();
                note(1'b0, $sformatf("%s frame missing strobe: actual none expected edge=%0d",
                                     e.tag, e.edge_no));
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 20000 && !finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        note(tref_err_cnt == 0 && frame_err_cnt == 0 && !tref_done && !frame_done
             && !tref_pass && !frame_pass,
             $sformatf("R1 in reset: cnt=%0d/%0d done=%0b/%0b expected 0/0 0/0",
                       tref_err_cnt, frame_err_cnt, tref_done, frame_done));
        rst = 1'b0;
        @(negedge clk);
        note(tref_err_cnt == 0 && frame_err_cnt == 0 && !tref_done && !frame_done,
             $sformatf("R1 after reset: cnt=%0d/%0d done=%0b/%0b expected 0/0 0/0",
                       tref_err_cnt, frame_err_cnt, tref_done, frame_done));

        do_window(1, 1, "R2 early lock");
        do_window(TW, FW, "R2 lock on last edge");
        do_window(TW + 1, FW + 1, "R3 lock one edge late");
        do_window(0, 3, "R4 tref fails frame passes");
        do_window(-1, -1, "R9 lock only on pulse edge");

        pulse_only(4);                        // R6: cut short, no result expected
        do_window(2, 0, "R6 after re-arm");

        pulse_only(TW - 1);                   // R7: next pulse lands on expiry edge
        do_window(0, 0, "R7 pulse on expiry edge");

        idle_toggle();

        for (int n = 0; n < 5; n++) do_window(0, 0, "R8 saturation");

        repeat (3) @(negedge clk);
        note(q_tref.size() == 0 && q_frame.size() == 0,
             $sformatf("R5 leftover expectations: actual %0d/%0d expected 0/0",
                       q_tref.size(), q_frame.size()));

        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        note(tref_err_cnt == 0 && frame_err_cnt == 0,
             $sformatf("R8 clear by reset: cnt=%0d/%0d expected 0/0",
                       tref_err_cnt, frame_err_cnt));

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule